// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects level-sensitive interrupt requests into two primary groups of eight lines each. Each group has a status register and a mask register. For each group the block drives a CPU request line and a 6-bit vector that names the winning source. A shared byte of secondary sources is filtered by two further mask registers. Each filtered secondary set folds into one reserved bit of a primary group. When that reserved bit wins, the group's vector names the secondary source instead.

A bus-error input drives its own CPU line. A 2-bit priority code tells the CPU which of its three lines it should serve first. A small register port lets software write the four mask registers and read them back, together with the three status bytes. An optional hardware link keeps each primary group's reserved mask bit in step with its secondary mask. Sources are cleared at their origin, not through this block.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset all four mask registers read zero, and every CPU line, vector and priority code is zero.
- R2: Register port: address 0 and 1 are the primary masks of group 0 and 1, and addresses 2 and 3 are the secondary masks 0 and 1; all four can be read and written. Addresses 4 and 5 return the group 0 and group 1 status, address 6 returns the latched secondary status, and address 7 returns zero. Writes to addresses 4 to 7 change nothing. Reads are combinational.
- R3: A group's pending set is its status AND its mask. Its CPU line is the OR of that set, registered. A source change shows on the outputs at the fourth rising edge after it is sampled: two synchronizer stages, the status latch, then the output register.
- R4: The group vector is the base plus the index of the highest pending bit, so bit 7 beats bit 0. Group 0's base is 8 and group 1's base is 16. An empty set gives vector 0.
- R5: Status bit 2 of group 0 is the OR of (secondary status AND secondary mask 0). The external group 0 line at bit 2 has no effect.
- R6: Status bit 3 of group 1 is the OR of (secondary status AND secondary mask 1). The external group 1 line at bit 3 has no effect.
- R7: While a group's reserved bit is pending, its vector is the secondary base plus the highest set bit of (secondary status AND that group's secondary mask). The secondary base is 24 for group 0 and 32 for group 1.
- R8: With the link enabled (the default), writing a nonzero value to secondary mask 0 sets bit 2 of primary mask 0, and writing zero clears it. Writes to secondary mask 1 act the same way on bit 3 of primary mask 1.
- R9: The priority code is 1 when group 0 requests, else 2 when group 1 requests, else 3 when bus error is raised, else 0.
- R10: The bus-error CPU line follows its input after two synchronizer stages and one output register, three edges after it is sampled.
- R11: A mask write sampled at one rising edge changes the CPU lines and vectors at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l0_src | input | 8 | Group 0 request lines (level) |
| l1_src | input | 8 | Group 1 request lines (level) |
| map_src | input | 8 | Shared secondary request lines (level) |
| berr_src | input | 1 | Bus-error request (level) |
| cfg_addr | input | 3 | Register port address |
| cfg_wen | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| cpu_irq_l0 | output | 1 | Group 0 CPU request |
| cpu_irq_l1 | output | 1 | Group 1 CPU request |
| cpu_irq_berr | output | 1 | Bus-error CPU request |
| vec_l0 | output | 6 | Group 0 winning vector, 0 when idle |
| vec_l1 | output | 6 | Group 1 winning vector, 0 when idle |
| top_req | output | 2 | Priority code of the CPU lines |

## Verification
The assertions assume that the register port carries at most one write per cycle, with address and data stable around the sampling edge. They also assume that requests are levels that hold for at least one cycle and do not need to be held longer for capture. The bench drives every input on the falling edge, so each input is stable at the rising edge that samples it. It issues writes as single-cycle strobes and never depends on a glitch being captured. Its random phase allows any address and any data, including writes to the read-only addresses, because the block must tolerate these.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
  localparam int GRP_W = 8;
  localparam int IDX_W = 3;
  localparam int VEC_W = 6;

  typedef enum logic [2:0] {
    A_LMASK0 = 3'd0,
    A_LMASK1 = 3'd1,
    A_MMASK0 = 3'd2,
    A_MMASK1 = 3'd3,
    A_LSTAT0 = 3'd4,
    A_LSTAT1 = 3'd5,
    A_MSTAT  = 3'd6,
    A_SPARE  = 3'd7
  } cfg_addr_e;

  typedef enum logic [1:0] {
    TOP_NONE = 2'd0,
    TOP_L0   = 2'd1,
    TOP_L1   = 2'd2,
    TOP_BERR = 2'd3
  } top_req_e;

  // index of the highest set bit; ascending scan keeps the last hit
  function automatic logic [IDX_W-1:0] top_index(input logic [GRP_W-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < GRP_W; i++) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  // base plus winner, or zero when nothing is set
  function automatic logic [VEC_W-1:0] make_vec(input logic [VEC_W-1:0] base,
                                                input logic [GRP_W-1:0] set);
    if (set == '0) return '0;
    return base + VEC_W'(top_index(set));
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import casc_irq_pkg::*;
#(
  parameter int CASC0_BIT = 2,
  parameter int CASC1_BIT = 3,
  parameter bit AUTO_LINK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wen,
  input  logic [2:0]       addr,
  input  logic [GRP_W-1:0] wdata,
  output logic [GRP_W-1:0] lmask0,
  output logic [GRP_W-1:0] lmask1,
  output logic [GRP_W-1:0] mmask0,
  output logic [GRP_W-1:0] mmask1
);
  logic wr_l0, wr_l1, wr_m0, wr_m1, wdata_any;

  assign wr_l0     = wen && (addr == A_LMASK0);
  assign wr_l1     = wen && (addr == A_LMASK1);
  assign wr_m0     = wen && (addr == A_MMASK0);
  assign wr_m1     = wen && (addr == A_MMASK1);
  assign wdata_any = |wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lmask0 <= '0;
      lmask1 <= '0;
      mmask0 <= '0;
      mmask1 <= '0;
    end else begin
      if (wr_l0) lmask0 <= wdata;
      if (wr_l1) lmask1 <= wdata;
      if (wr_m0) begin
        mmask0 <= wdata;
        if (AUTO_LINK) lmask0[CASC0_BIT] <= wdata_any;
      end
      if (wr_m1) begin
        mmask1 <= wdata;
        if (AUTO_LINK) lmask1[CASC1_BIT] <= wdata_any;
      end
    end
  end

  // R11
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_l0 |=> (lmask0 == $past(wdata)));

  // R8
  link_m0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (AUTO_LINK && wr_m0) |=> (lmask0[CASC0_BIT] == ($past(wdata) != '0)));

  // R8
  link_m1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (AUTO_LINK && wr_m1) |=> (lmask1[CASC1_BIT] == ($past(wdata) != '0)));
endmodule

// File: rtl/irq_group_resolve.sv
module irq_group_resolve
  import casc_irq_pkg::*;
#(
  parameter int CASC_BIT = 2,
  parameter int LBASE    = 8,
  parameter int MBASE    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] stat,
  input  logic [GRP_W-1:0] lmask,
  input  logic [GRP_W-1:0] map_stat,
  input  logic [GRP_W-1:0] mmask,
  output logic [GRP_W-1:0] stat_full,
  output logic [GRP_W-1:0] pend,
  output logic             casc_hit,
  output logic             req_nxt,
  output logic [VEC_W-1:0] vec_nxt
);
  localparam logic [VEC_W-1:0] LB = VEC_W'(LBASE);
  localparam logic [VEC_W-1:0] MB = VEC_W'(MBASE);

  logic [GRP_W-1:0] sub;

  always_comb begin
    sub                 = map_stat & mmask;
    stat_full           = stat;
    stat_full[CASC_BIT] = |sub;
    pend                = stat_full & lmask;
    casc_hit            = pend[CASC_BIT];
    req_nxt             = |pend;
    vec_nxt             = casc_hit ? make_vec(MB, sub) : make_vec(LB, pend);
  end

  // R7
  casc_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    casc_hit |-> (vec_nxt >= MB) && (vec_nxt < MB + VEC_W'(GRP_W)));

  // R4
  local_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_nxt && !casc_hit) |-> (vec_nxt >= LB) && (vec_nxt < LB + VEC_W'(GRP_W)));

  // R5
  casc_src_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[CASC_BIT] && (sub == '0)) |-> !pend[CASC_BIT]);
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import casc_irq_pkg::*;
#(
  parameter int CASC0_BIT   = 2,
  parameter int CASC1_BIT   = 3,
  parameter bit AUTO_LINK   = 1'b1,
  parameter int SYNC_STAGES = 2,
  parameter int L0_BASE     = 8,
  parameter int L1_BASE     = 16,
  parameter int M0_BASE     = 24,
  parameter int M1_BASE     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] l0_src,
  input  logic [GRP_W-1:0] l1_src,
  input  logic [GRP_W-1:0] map_src,
  input  logic             berr_src,
  input  logic [2:0]       cfg_addr,
  input  logic             cfg_wen,
  input  logic [GRP_W-1:0] cfg_wdata,
  output logic [GRP_W-1:0] cfg_rdata,
  output logic             cpu_irq_l0,
  output logic             cpu_irq_l1,
  output logic             cpu_irq_berr,
  output logic [VEC_W-1:0] vec_l0,
  output logic [VEC_W-1:0] vec_l1,
  output logic [1:0]       top_req
);
  localparam int NGRP   = 2;
  localparam int SYNC_W = 3 * GRP_W + 1;

  logic [SYNC_W-1:0] sync_q;
  logic [GRP_W-1:0]  l0_s, l1_s, map_s;
  logic              berr_s;

  irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({berr_src, map_src, l1_src, l0_src}),
    .q     (sync_q)
  );

  assign {berr_s, map_s, l1_s, l0_s} = sync_q;

  // status latch
  logic [GRP_W-1:0] lstat_q [NGRP];
  logic [GRP_W-1:0] mstat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lstat_q[0] <= '0;
      lstat_q[1] <= '0;
      mstat_q    <= '0;
    end else begin
      lstat_q[0] <= l0_s;
      lstat_q[1] <= l1_s;
      mstat_q    <= map_s;
    end
  end

  logic [GRP_W-1:0] lmask [NGRP];
  logic [GRP_W-1:0] mmask [NGRP];

  irq_mask_regs #(
    .CASC0_BIT (CASC0_BIT),
    .CASC1_BIT (CASC1_BIT),
    .AUTO_LINK (AUTO_LINK)
  ) u_masks (
    .clk    (clk),
    .rst_n  (rst_n),
    .wen    (cfg_wen),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .lmask0 (lmask[0]),
    .lmask1 (lmask[1]),
    .mmask0 (mmask[0]),
    .mmask1 (mmask[1])
  );

  logic [GRP_W-1:0] stat_full [NGRP];
  logic [GRP_W-1:0] pend      [NGRP];
  logic             casc_hit  [NGRP];
  logic             req_nxt   [NGRP];
  logic [VEC_W-1:0] vec_nxt   [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    irq_group_resolve #(
      .CASC_BIT ((g == 0) ? CASC0_BIT : CASC1_BIT),
      .LBASE    ((g == 0) ? L0_BASE   : L1_BASE),
      .MBASE    ((g == 0) ? M0_BASE   : M1_BASE)
    ) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat      (lstat_q[g]),
      .lmask     (lmask[g]),
      .map_stat  (mstat_q),
      .mmask     (mmask[g]),
      .stat_full (stat_full[g]),
      .pend      (pend[g]),
      .casc_hit  (casc_hit[g]),
      .req_nxt   (req_nxt[g]),
      .vec_nxt   (vec_nxt[g])
    );
  end

  top_req_e top_nxt;

  always_comb begin
    if (req_nxt[0])      top_nxt = TOP_L0;
    else if (req_nxt[1]) top_nxt = TOP_L1;
    else if (berr_s)     top_nxt = TOP_BERR;
    else                 top_nxt = TOP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq_l0   <= 1'b0;
      cpu_irq_l1   <= 1'b0;
      cpu_irq_berr <= 1'b0;
      vec_l0       <= '0;
      vec_l1       <= '0;
      top_req      <= TOP_NONE;
    end else begin
      cpu_irq_l0   <= req_nxt[0];
      cpu_irq_l1   <= req_nxt[1];
      cpu_irq_berr <= berr_s;
      vec_l0       <= vec_nxt[0];
      vec_l1       <= vec_nxt[1];
      top_req      <= top_nxt;
    end
  end

  always_comb begin
    unique case (cfg_addr)
      A_LMASK0: cfg_rdata = lmask[0];
      A_LMASK1: cfg_rdata = lmask[1];
      A_MMASK0: cfg_rdata = mmask[0];
      A_MMASK1: cfg_rdata = mmask[1];
      A_LSTAT0: cfg_rdata = stat_full[0];
      A_LSTAT1: cfg_rdata = stat_full[1];
      A_MSTAT:  cfg_rdata = mstat_q;
      default:  cfg_rdata = '0;
    endcase
  end

  // R9
  top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_req == TOP_L1) |-> (!cpu_irq_l0 && cpu_irq_l1));

  // R9
  top_berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_req == TOP_BERR) |-> (!cpu_irq_l0 && !cpu_irq_l1 && cpu_irq_berr));

  // R3
  req_vec_l0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_l0 == (vec_l0 != '0));

  // R3
  req_vec_l1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_l1 == (vec_l1 != '0));

  // R10
  berr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_s) |=> cpu_irq_berr);
endmodule

// File: tb/cascade_irq_ctrl_bench.sv
module cascade_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] l0_src = '0, l1_src = '0, map_src = '0;
  logic       berr_src = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic       cfg_wen = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       cpu_irq_l0, cpu_irq_l1, cpu_irq_berr;
  logic [5:0] vec_l0, vec_l1;
  logic [1:0] top_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit live   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_irq_ctrl u_cascade_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .l0_src(l0_src), .l1_src(l1_src),
    .map_src(map_src), .berr_src(berr_src), .cfg_addr(cfg_addr),
    .cfg_wen(cfg_wen), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_irq_l0(cpu_irq_l0), .cpu_irq_l1(cpu_irq_l1),
    .cpu_irq_berr(cpu_irq_berr), .vec_l0(vec_l0), .vec_l1(vec_l1),
    .top_req(top_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int hbit(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  // behavioural reference: histories of the inputs plus mask state
  logic [7:0] h_l0 [$], h_l1 [$], h_map [$];
  bit         h_b  [$];
  logic [7:0] m_lm0, m_lm1, m_mm0, m_mm1, m_st0, m_st1, m_mst;
  int         e_vec0, e_vec1, e_top;
  bit         e_req0, e_req1, e_berr;

  function automatic logic [7:0] full_stat(input int g);
    logic [7:0] s;
    s = (g == 0) ? m_st0 : m_st1;
    if (g == 0) s[2] = ((m_mst & m_mm0) != 0);
    else        s[3] = ((m_mst & m_mm1) != 0);
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h_l0 = {8'h0, 8'h0}; h_l1 = {8'h0, 8'h0};
      h_map = {8'h0, 8'h0}; h_b = {1'b0, 1'b0};
      m_lm0 = 0; m_lm1 = 0; m_mm0 = 0; m_mm1 = 0;
      m_st0 = 0; m_st1 = 0; m_mst = 0;
      e_vec0 = 0; e_vec1 = 0; e_top = 0;
      e_req0 = 0; e_req1 = 0; e_berr = 0;
    end else begin
      logic [7:0] p0, p1, s0, s1;
      s0 = m_mst & m_mm0;
      s1 = m_mst & m_mm1;
      p0 = full_stat(0) & m_lm0;
      p1 = full_stat(1) & m_lm1;
      e_req0 = (p0 != 0);
      e_req1 = (p1 != 0);
      e_vec0 = p0[2] ? 24 + hbit(s0) : (e_req0 ? 8 + hbit(p0) : 0);
      e_vec1 = p1[3] ? 32 + hbit(s1) : (e_req1 ? 16 + hbit(p1) : 0);
      e_berr = h_b[0];
      e_top  = e_req0 ? 1 : e_req1 ? 2 : h_b[0] ? 3 : 0;
      m_st0 = h_l0[0]; m_st1 = h_l1[0]; m_mst = h_map[0];
      void'(h_l0.pop_front()); void'(h_l1.pop_front());
      void'(h_map.pop_front()); void'(h_b.pop_front());
      h_l0.push_back(l0_src); h_l1.push_back(l1_src);
      h_map.push_back(map_src); h_b.push_back(berr_src);
      if (cfg_wen) begin
        case (cfg_addr)
          3'd0: m_lm0 = cfg_wdata;
          3'd1: m_lm1 = cfg_wdata;
          3'd2: begin m_mm0 = cfg_wdata; m_lm0[2] = (cfg_wdata != 0); end
          3'd3: begin m_mm1 = cfg_wdata; m_lm1[3] = (cfg_wdata != 0); end
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_lm0;
      3'd1: return m_lm1;
      3'd2: return m_mm0;
      3'd3: return m_mm1;
      3'd4: return full_stat(0);
      3'd5: return full_stat(1);
      3'd6: return m_mst;
      default: return 0;
    endcase
  endfunction

  // every-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    cycles++;
    #(CLK_PERIOD/4);
    if (live) begin
      check("R3 cpu_irq_l0", cpu_irq_l0, e_req0);
      check("R3 cpu_irq_l1", cpu_irq_l1, e_req1);
      check("R4 vec_l0", vec_l0, e_vec0);
      check("R4 vec_l1", vec_l1, e_vec1);
      check("R9 top_req", top_req, e_top);
      check("R10 cpu_irq_berr", cpu_irq_berr, e_berr);
      check("R2 cfg_rdata", cfg_rdata, exp_read(cfg_addr));
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wen = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wen = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live  = 1'b1;
    // R1 reset state
    #1;
    check("R1 vec_l0", vec_l0, 0);
    check("R1 top_req", top_req, 0);
    check("R1 cpu_irq_l1", cpu_irq_l1, 0);
    for (int a = 0; a < 4; a++) rd_chk("R1 mask read", 3'(a), 0);

    // R5 external bit 2 ignored, R4 highest bit wins
    wr(3'd0, 8'hFF);
    @(negedge clk); l0_src = 8'h04;
    settle();
    check("R5 cpu_irq_l0 ext bit2", cpu_irq_l0, 0);
    @(negedge clk); l0_src = 8'h81;
    settle();
    check("R4 vec_l0 bit7", vec_l0, 15);
    @(negedge clk); l0_src = 8'h01;
    settle();
    check("R4 vec_l0 bit0", vec_l0, 8);

    // R7 cascade wins over local bits, R8 link
    @(negedge clk); map_src = 8'h30; l0_src = 8'hFB;
    wr(3'd0, 8'hFB);
    rd_chk("R8 lmask0 bit2 clear", 3'd0, 8'hFB);
    wr(3'd2, 8'h10);
    rd_chk("R8 lmask0 bit2 set", 3'd0, 8'hFF);
    settle();
    check("R7 vec_l0 cascade", vec_l0, 28);
    wr(3'd2, 8'h00);
    rd_chk("R8 lmask0 bit2 cleared", 3'd0, 8'hFB);
    settle();
    check("R4 vec_l0 after unlink", vec_l0, 15);

    // R6 group 1 cascade, R9 priority
    @(negedge clk); l0_src = 8'h00; map_src = 8'h21; l1_src = 8'h08;
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h21);
    rd_chk("R8 lmask1 bit3 set", 3'd1, 8'h08);
    settle();
    check("R6 vec_l1 cascade", vec_l1, 37);
    check("R9 top_req group1", top_req, 2);
    rd_chk("R2 read-only write", 3'd6, 8'h21);
    wr(3'd6, 8'h00);
    rd_chk("R2 status unchanged", 3'd6, 8'h21);

    // R10 bus error below group 1
    wr(3'd3, 8'h00);
    @(negedge clk); berr_src = 1'b1;
    settle();
    check("R10 cpu_irq_berr", cpu_irq_berr, 1);
    check("R9 top_req berr", top_req, 3);
    @(negedge clk); berr_src = 1'b0;

    // R11 mask write timing
    @(negedge clk); l1_src = 8'h01;
    settle();
    @(negedge clk);
    cfg_wen = 1'b1; cfg_addr = 3'd1; cfg_wdata = 8'h01;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R11 before", cpu_irq_l1, 0);
    @(negedge clk); cfg_wen = 1'b0;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R11 after", cpu_irq_l1, 1);

    // random phase
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      l0_src = 8'($urandom); l1_src = 8'($urandom);
      map_src = 8'($urandom); berr_src = 1'($urandom);
      cfg_addr = 3'($urandom);
      cfg_wdata = 8'($urandom);
      cfg_wen = (($urandom % 4) == 0);
    end
    @(negedge clk); cfg_wen = 1'b0;
    settle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule